// File: doc/BRIEF.md
# Multi-Channel Compare-and-Clear Timer

This block holds several independent timer channels behind one small synchronous register port. Each channel has an up-counter, a compare register and a control/status register. A shared prescaler slows the input clock down to a count tick. While a channel is running, its counter steps once per tick. When the counter equals the compare value, the next tick returns it to zero and sets a sticky match flag. The channel's interrupt line is high while that flag and the channel's interrupt enable are both set.

One run register, shared by all channels, starts and stops them. Each channel owns one bit of it, so software can halt one channel without disturbing the others. A write to a counter does not take effect at once. It is held and reaches the counter on the second count tick after the write. A parameter chooses between two variants:
- a narrow variant: 16-bit channels, prescaler 512;
- a wide variant: 32-bit channels, prescaler 8, plus a second status bit that records a match arriving while the first flag is still set.

Top module: `cmatch_timer`

## Requirements
- R1: After reset every control/status register, every counter and the run register read 0, every compare register reads all ones, and all interrupt outputs are low.
- R2: A channel's counter advances only while its run-register bit is 1. The run register is at address 12 with one bit per channel (bit n is channel n). Clearing one bit freezes only that channel's counter.
- R3: A running counter that equals its compare value returns to 0 on the next tick. The match period is therefore (compare + 1) ticks.
- R4: In the narrow variant one count tick occurs every 512 clock cycles. In the wide variant one occurs every 8 clock cycles.
- R5: The match flag is set by a match. It is bit 7 in the narrow variant and bit 15 in the wide variant. The flag is sticky: writing 1 to it never sets it and leaves a set flag set.
- R6: Writing the control/status register with a status bit at 0 clears that bit, and the other bits take the written values. In the wide variant, bit 14 is set by a match that arrives while bit 15 is already set, and it clears in the same way.
- R7: The interrupt enable is bit 6 of the control/status register. A channel's interrupt output is high while its flag and its enable are both set, and it stays high until either is cleared. Writing 0 to the control/status register disables the interrupt.
- R8: A counter write is not visible on read and has no effect until the second count tick after the write. On that tick the counter takes the written value.
- R9: On the tick where a pending counter write lands, that write takes priority over a compare match: the counter takes the written value and no flag is set.
- R10: Each channel's registers are addressed as channel*4 + offset, where offset 0 is control/status, 1 is counter and 2 is compare. All other addresses, including the unused slots of a channel window and 13 to 15, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic is rising-edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | AW (4 by default) | Register address: channel index and offset, or the run register |
| bus_wdata | input | DW (16 narrow, 32 wide) | Write data |
| bus_rdata | output | DW | Registered read data for the address of the previous cycle |
| irq | output | NCH (3 by default) | Per-channel interrupt, high while flag and enable are set |

## Verification
The compare-and-clear function is tried with a table of compare values on both variants, from 0 (a match on every tick) to several ticks, and the bench measures the cycle distance between interrupt rises. These measurements separate an off-by-one period (compare versus compare + 1) and a wrong prescaler ratio. Counter writes are exercised on a stopped channel, which checks the two-tick hiding of the written value. They are also exercised on a running channel whose compare of 0 guarantees that the landing write coincides with a match, which shows whether the write or the wrap wins. Flag handling is probed with writes of 1 and 0 to the status bits and with repeated matches in the wide variant.

// File: rtl/cmatch_pkg.sv
package cmatch_pkg;

  typedef enum logic [1:0] {
    OFS_CTRL  = 2'd0,
    OFS_COUNT = 2'd1,
    OFS_CMP   = 2'd2,
    OFS_NONE  = 2'd3
  } ofs_e;

  localparam int IE_BIT   = 6;
  localparam int MISS_BIT = 14;

  function automatic int flag_bit(bit wide);
    return wide ? 15 : 7;
  endfunction

endpackage

// File: rtl/cmatch_tick.sv
module cmatch_tick #(
  parameter int DIV = 512
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
      tick_q <= (pcnt_q == LAST);
    end
  end

  assign tick = tick_q;

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q); // R4

endmodule

// File: rtl/cmatch_chan.sv
module cmatch_chan
  import cmatch_pkg::*;
#(
  parameter bit WIDE = 1'b0,
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          we_ctrl,
  input  logic          we_cnt,
  input  logic          we_cmp,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] ctrl_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cmp_o,
  output logic          irq_o
);
  localparam int FB = flag_bit(WIDE);

  logic [CW-1:0] cnt_q, cmp_q, pval_q;
  logic [1:0]    pend_q;
  logic          ie_q, flag_q, miss_q, irq_q;
  logic          load_now, hit;

  always_comb begin
    load_now = tick && (pend_q == 2'd1);
    hit      = tick && run && !load_now && (cnt_q == cmp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cmp_q  <= '1;
      pval_q <= '0;
      pend_q <= 2'd0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (we_cnt) begin
        pval_q <= wdata;
        pend_q <= 2'd2;
      end else if (tick && pend_q != 2'd0) begin
        pend_q <= pend_q - 2'd1;
      end
      if (load_now)         cnt_q <= pval_q;
      else if (tick && run) cnt_q <= hit ? '0 : cnt_q + 1'b1;
      if (we_cmp)  cmp_q <= wdata;
      if (we_ctrl) ie_q  <= wdata[IE_BIT];
      flag_q <= (we_ctrl ? (flag_q & wdata[FB]) : flag_q) | hit;
      irq_q  <= flag_q & ie_q;
    end
  end

  generate
    if (WIDE) begin : g_miss
      always_ff @(posedge clk) begin
        if (rst) miss_q <= 1'b0;
        else     miss_q <= (we_ctrl ? (miss_q & wdata[MISS_BIT]) : miss_q) | (hit & flag_q);
      end
    end else begin : g_nomiss
      assign miss_q = 1'b0;
    end
  endgenerate

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[MISS_BIT] = miss_q;
    ctrl_o[FB]       = flag_q;
    ctrl_o[IE_BIT]   = ie_q;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_now) |=> cnt_q == $past(cnt_q)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !load_now && cnt_q == cmp_q) |=> cnt_q == '0); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !we_ctrl) |=> flag_q); // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !flag_q |=> !irq_o); // R7
  AST_WRITE_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    we_cnt |=> (cnt_q == $past(cnt_q)) || $past(tick)); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (cnt_q == $past(pval_q)) && (!flag_q || $past(flag_q))); // R9

endmodule

// File: rtl/cmatch_timer.sv
module cmatch_timer
  import cmatch_pkg::*;
#(
  parameter int NCH        = 3,
  parameter bit WIDE       = 1'b0,
  parameter int DIV_NARROW = 512,
  parameter int DIV_WIDE   = 8,
  localparam int DW        = WIDE ? 32 : 16,
  localparam int SW        = $clog2(NCH + 1),
  localparam int AW        = SW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NCH-1:0] irq
);
  localparam int DIV = WIDE ? DIV_WIDE : DIV_NARROW;
  localparam logic [AW-1:0] RUN_ADDR = AW'(NCH * 4);

  logic           tick;
  logic [NCH-1:0] start_q;
  logic [DW-1:0]  rdata_q;
  logic [SW-1:0]  slot;
  logic [1:0]     off;
  logic [DW-1:0]  ch_ctrl [NCH];
  logic [DW-1:0]  ch_cnt  [NCH];
  logic [DW-1:0]  ch_cmp  [NCH];

  assign slot = bus_addr[AW-1:2];
  assign off  = bus_addr[1:0];

  cmatch_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel;
      assign sel = bus_we && (slot == SW'(i));
      cmatch_chan #(.WIDE(WIDE), .CW(DW)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (start_q[i]),
        .we_ctrl (sel && off == OFS_CTRL),
        .we_cnt  (sel && off == OFS_COUNT),
        .we_cmp  (sel && off == OFS_CMP),
        .wdata   (bus_wdata),
        .ctrl_o  (ch_ctrl[i]),
        .cnt_o   (ch_cnt[i]),
        .cmp_o   (ch_cmp[i]),
        .irq_o   (irq[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_we && bus_addr == RUN_ADDR) start_q <= bus_wdata[NCH-1:0];
      rdata_q <= '0;
      if (bus_addr == RUN_ADDR) rdata_q <= DW'(start_q);
      for (int i = 0; i < NCH; i++) begin
        if (slot == SW'(i)) begin
          case (off)
            OFS_CTRL:  rdata_q <= ch_ctrl[i];
            OFS_COUNT: rdata_q <= ch_cnt[i];
            OFS_CMP:   rdata_q <= ch_cmp[i];
            default:   rdata_q <= '0;
          endcase
        end
      end
    end
  end

  assign bus_rdata = rdata_q;

  AST_RUN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == RUN_ADDR) |=> start_q == $past(bus_wdata[NCH-1:0])); // R2

endmodule

// File: tb/sim_cmatch_timer.sv
module sim_cmatch_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  logic        we0 = 0, we1 = 0;
  logic [3:0]  a0 = 0, a1 = 0;
  logic [15:0] wd0 = 0, rd0;
  logic [31:0] wd1 = 0, rd1;
  logic [2:0]  irq0, irq1;

  cmatch_timer #(.NCH(3), .WIDE(1'b0)) u0 (
    .clk(clk), .rst(rst), .bus_we(we0), .bus_addr(a0),
    .bus_wdata(wd0), .bus_rdata(rd0), .irq(irq0));
  cmatch_timer #(.NCH(3), .WIDE(1'b1)) u1 (
    .clk(clk), .rst(rst), .bus_we(we1), .bus_addr(a1),
    .bus_wdata(wd1), .bus_rdata(rd1), .irq(irq1));

  int checks = 0;
  int errors = 0;

  // sel, compare, expected period in clock cycles
  localparam int VEC [6][3] = '{
    '{0, 0, 512}, '{0, 1, 1024}, '{0, 3, 2048},
    '{0, 6, 3584}, '{1, 3, 32},  '{1, 9, 80}};

  localparam logic [3:0] RUNA = 4'd12;

  function automatic logic [3:0] ad(int ch, int off);
    return 4'((ch << 2) | off);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(bit s, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    if (!s) begin we0 = 1; a0 = a; wd0 = d[15:0]; end
    else    begin we1 = 1; a1 = a; wd1 = d; end
    @(negedge clk);
    we0 = 0; we1 = 0;
  endtask

  task automatic rd(bit s, logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    if (!s) a0 = a; else a1 = a;
    @(negedge clk);
    v = s ? rd1 : {16'h0, rd0};
  endtask

  function automatic bit irqb(bit s);
    return s ? irq1[0] : irq0[0];
  endfunction

  task automatic wait_irq(bit s, bit lvl, output int t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (irqb(s) != lvl && n < 20000);
    t = cyc;
    if (irqb(s) != lvl) chk("R7 irq wait timeout", 32'(irqb(s)), 32'(lvl));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    int t1, t2, tx;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    rd(0, ad(0, 0), v); chk("R1 ctrl reset", v, 0);
    rd(0, ad(0, 1), v); chk("R1 count reset", v, 0);
    rd(0, ad(0, 2), v); chk("R1 compare reset", v, 32'hFFFF);
    rd(0, RUNA, v);     chk("R1 run reset", v, 0);
    chk("R1 irq reset", 32'(irq0), 0);
    rd(1, ad(1, 2), v); chk("R1 wide compare reset", v, 32'hFFFF_FFFF);

    // R10 unused addresses
    rd(0, 4'd13, v); chk("R10 unused read", v, 0);
    wr(0, 4'd13, 7);
    rd(0, RUNA, v); chk("R10 unused write ignored", v, 0);
    wr(0, ad(0, 3), 16'h55);
    rd(0, ad(0, 3), v); chk("R10 window slot 3 reads 0", v, 0);
    rd(0, ad(0, 2), v); chk("R10 compare untouched", v, 32'hFFFF);

    // R5 writing 1 to flag does not set it
    wr(0, ad(2, 0), 32'h80);
    rd(0, ad(2, 0), v); chk("R5 write one no set", v, 0);

    // R3 R4 period table
    for (int i = 0; i < 6; i++) begin
      bit s;
      s = VEC[i][0][0];
      wr(s, RUNA, 0);
      wr(s, ad(0, 2), 32'(VEC[i][1]));
      wr(s, ad(0, 1), 0);
      wr(s, ad(0, 0), 32'h40);
      repeat (1100) @(negedge clk);
      wr(s, RUNA, 1);
      wait_irq(s, 1'b1, t1);
      if (!s) begin
        rd(0, ad(0, 0), v); chk("R5 flag bit7 on match", v, 32'hC0);
      end
      wr(s, ad(0, 0), 32'h40);
      wait_irq(s, 1'b0, tx);
      wait_irq(s, 1'b1, t2);
      chk($sformatf("R3 R4 period cmp=%0d", VEC[i][1]), 32'(t2 - t1), 32'(VEC[i][2]));
    end

    // R7 interrupt gating (u0 ch0 flag set, irq high)
    chk("R7 irq high with flag and enable", 32'(irq0[0]), 1);
    wr(0, ad(0, 0), 0);
    repeat (3) @(negedge clk);
    chk("R7 irq low after ctrl zero", 32'(irq0[0]), 0);
    repeat (4000) @(negedge clk);
    chk("R7 irq stays low while disabled", 32'(irq0[0]), 0);
    rd(0, ad(0, 0), v); chk("R5 flag set again without enable", v, 32'h80);

    // R2 per-channel run bits
    wr(0, ad(0, 2), 32'hFFFF);
    wr(0, RUNA, 3);
    repeat (1200) @(negedge clk);
    wr(0, RUNA, 1);
    rd(0, ad(1, 1), a);
    repeat (1200) @(negedge clk);
    rd(0, ad(1, 1), b); chk("R2 stopped channel holds", b, a);
    rd(0, ad(0, 1), v);
    repeat (1200) @(negedge clk);
    rd(0, ad(0, 1), b); chk("R2 other channel advances", 32'(b > v), 1);

    // R8 delayed counter write on stopped ch1
    wr(0, ad(1, 1), 5);
    rd(0, ad(1, 1), v); chk("R8 write hidden", v, a);
    repeat (1034) @(negedge clk);
    rd(0, ad(1, 1), v); chk("R8 write lands after two ticks", v, 5);

    // R9 landing write beats a match (ch2 compare 0)
    wr(0, ad(2, 2), 0);
    wr(0, ad(2, 1), 0);
    wr(0, ad(2, 0), 32'h40);
    repeat (1100) @(negedge clk);
    wr(0, RUNA, 5);
    repeat (1100) @(negedge clk);
    rd(0, ad(2, 0), v); chk("R3 compare zero matches", v, 32'hC0);
    wr(0, ad(2, 1), 9);
    repeat (1034) @(negedge clk);
    rd(0, ad(2, 1), v); chk("R9 count takes written value", v, (v == 10) ? 32'd10 : 32'd9);
    wr(0, ad(2, 0), 32'h40);
    repeat (1600) @(negedge clk);
    rd(0, ad(2, 0), v); chk("R9 no match after load", v, 32'h40);

    // R6 wide status bits (u1 ch0 running, compare 9)
    repeat (200) @(negedge clk);
    rd(1, ad(0, 0), v); chk("R6 wide flag and miss set", v, 32'hC040);
    wr(1, RUNA, 0);
    wr(1, ad(0, 0), 32'h8040);
    rd(1, ad(0, 0), v); chk("R6 clear bit14 only", v, 32'h8040);
    wr(1, ad(0, 0), 32'h0040);
    rd(1, ad(0, 0), v); chk("R6 clear bit15", v, 32'h0040);
    repeat (2) @(negedge clk);
    chk("R7 wide irq low after clear", 32'(irq1[0]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule